// File: doc/BRIEF.md
# Synchronous Dual-Port RAM with Per-Port Read Latency Select

This block is a true dual-port synchronous static RAM. It has two equal ports, left and right. Each port has its own clock, address, read/write strobe, active-low and active-high chip select, output enable, write data, read data and a read-mode pin. Every port input except output enable is captured on the rising edge of that port's clock. Output enable gates the read result without waiting for a clock edge.

The read-mode pin picks the read path for each port. When the pin is low, the port is flow-through: the word is presented right after the edge that captured its address. When the pin is high, the port is pipelined: the word is presented one edge later. Read data is never tri-stated. A per-port valid flag stands in for the output drivers being on.

An address-load strobe decides where the address comes from on each edge. While the strobe is low, the address pins are loaded on every edge. While it is high, the port reuses the address it held on the previous edge. When both ports write one word on the same edge of a shared clock, the left port's data is kept.

Top module: `dpram_dual`

## Requirements
- R1: In flow-through mode (`pipe_*` = 0), a read captured on a rising edge shows the addressed word on `dout_*` with `dval_*` = 1 right after that same edge.
- R2: In pipelined mode (`pipe_*` = 1), the word read on an edge appears after the following edge. After the capturing edge itself, `dval_*` still reflects the preceding cycle.
- R3: A write happens on a rising edge when the port is selected and `rw_*` = 0 (`rw_*` = 1 means read). It stores `din_*` at the captured address. No valid read result comes from a write cycle.
- R4: A port is selected only when `cs_n_*` = 0 and `cs_*` = 1. In the other three combinations no write takes place and no valid read result is produced.
- R5: A deselect turns off the flow-through output right after the edge that captures it. In pipelined mode the output turns off only after the next edge, and the word read before the deselect is shown for one more cycle.
- R6: `dval_*` is low whenever `oe_n_*` is high, and follows `oe_n_*` with no clock edge in between. `dout_*` keeps its word while output enable toggles.
- R7: With `ld_n_*` = 0 the address pins are loaded on every edge. With `ld_n_*` = 1 the port reads or writes the address captured on its previous edge, and the address pins are ignored.
- R8: If both ports write the same address on the same edge of a shared clock, the left port's data is stored.
- R9: A read on one port and a write to the same address on the other port, on the same edge, return the word as it was before the write.
- R10: The two ports work independently. Writes to different addresses on the same edge are both stored, and each port keeps its own read mode.
- R11: While `rst_n` is low, both valid flags are low. Right after reset, an unselected port shows no valid data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset of the valid pipelines and held addresses |
| clk_l | input | 1 | Left port clock |
| cs_n_l | input | 1 | Left active-low chip select |
| cs_l | input | 1 | Left active-high chip select |
| rw_l | input | 1 | Left read (1) / write (0) |
| ld_n_l | input | 1 | Left address load strobe, active low |
| oe_n_l | input | 1 | Left output enable, active low, unclocked |
| pipe_l | input | 1 | Left read mode: 0 flow-through, 1 pipelined |
| addr_l | input | ADDR_W | Left address |
| din_l | input | DATA_W | Left write data |
| dout_l | output | DATA_W | Left read data |
| dval_l | output | 1 | Left read data valid (output drivers on) |
| clk_r | input | 1 | Right port clock |
| cs_n_r | input | 1 | Right active-low chip select |
| cs_r | input | 1 | Right active-high chip select |
| rw_r | input | 1 | Right read (1) / write (0) |
| ld_n_r | input | 1 | Right address load strobe, active low |
| oe_n_r | input | 1 | Right output enable, active low, unclocked |
| pipe_r | input | 1 | Right read mode: 0 flow-through, 1 pipelined |
| addr_r | input | ADDR_W | Right address |
| din_r | input | DATA_W | Right write data |
| dout_r | output | DATA_W | Right read data |
| dval_r | output | 1 | Right read data valid (output drivers on) |

## Verification
The hardest cases to reach are the cross-port ones: both ports writing one word on the same edge, and one port reading a word on the edge where the other port overwrites it. These only happen when both clocks rise together. The bench therefore drives both port clocks from a single source and sets up both ports before the same edge. It then reads the word back through one port to see which value was stored. Output enable is toggled between clock edges, so the bench can confirm that the valid flag follows it without any edge in between.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

   typedef enum logic {
      MODE_FLOW = 1'b0,
      MODE_PIPE = 1'b1
   } rd_mode_e;

   function automatic logic port_selected(input logic cs_n, input logic cs);
      return (!cs_n) && cs;
   endfunction

endpackage

// File: rtl/dpram_bank.sv
module dpram_bank #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 9
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr_a,
   output logic [DATA_W-1:0] rdata_a,
   input  logic [ADDR_W-1:0] raddr_b,
   output logic [DATA_W-1:0] rdata_b
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata_a = mem[raddr_a];
   assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/dpram_port.sv
module dpram_port
   import dpram_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              cs,
   input  logic              rw,
   input  logic              ld_n,
   input  logic              oe_n,
   input  logic              pipe,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] rd_word,
   output logic [ADDR_W-1:0] eff_addr,
   output logic              wr_now,
   output logic [DATA_W-1:0] dout,
   output logic              dval
);
   logic              sel;
   logic              rd_now;
   logic [ADDR_W-1:0] addr_q;
   logic              v_stage1, v_stage2;
   logic [DATA_W-1:0] q_stage1, q_stage2;

   assign sel      = port_selected(cs_n, cs);
   assign rd_now   = sel && rw;
   assign wr_now   = sel && !rw;
   assign eff_addr = ld_n ? addr_q : addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q   <= '0;
         v_stage1 <= 1'b0;
         v_stage2 <= 1'b0;
      end else begin
         addr_q   <= eff_addr;
         v_stage1 <= rd_now;
         v_stage2 <= v_stage1;
      end
   end

   always_ff @(posedge clk) begin
      if (rd_now) q_stage1 <= rd_word;
      q_stage2 <= q_stage1;
   end

   always_comb begin
      if (rd_mode_e'(pipe) == MODE_PIPE) begin
         dout = q_stage2;
         dval = v_stage2 && !oe_n;
      end else begin
         dout = q_stage1;
         dval = v_stage1 && !oe_n;
      end
   end
endmodule

// File: rtl/dpram_dual.sv
module dpram_dual #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 9
) (
   input  logic              rst_n,
   input  logic              clk_l,
   input  logic              cs_n_l,
   input  logic              cs_l,
   input  logic              rw_l,
   input  logic              ld_n_l,
   input  logic              oe_n_l,
   input  logic              pipe_l,
   input  logic [ADDR_W-1:0] addr_l,
   input  logic [DATA_W-1:0] din_l,
   output logic [DATA_W-1:0] dout_l,
   output logic              dval_l,
   input  logic              clk_r,
   input  logic              cs_n_r,
   input  logic              cs_r,
   input  logic              rw_r,
   input  logic              ld_n_r,
   input  logic              oe_n_r,
   input  logic              pipe_r,
   input  logic [ADDR_W-1:0] addr_r,
   input  logic [DATA_W-1:0] din_r,
   output logic [DATA_W-1:0] dout_r,
   output logic              dval_r
);
   localparam int NPORT = 2;
   localparam int LEFT  = 0;

   if (ADDR_W < 4 || ADDR_W > 14) begin : g_bad_addr_w
      $error("dpram_dual: ADDR_W must lie in 4..14");
   end
   if (DATA_W < 1) begin : g_bad_data_w
      $error("dpram_dual: DATA_W must be at least 1");
   end

   logic              clk_v  [NPORT];
   logic              csn_v  [NPORT];
   logic              cs_v   [NPORT];
   logic              rw_v   [NPORT];
   logic              ldn_v  [NPORT];
   logic              oen_v  [NPORT];
   logic              pipe_v [NPORT];
   logic [ADDR_W-1:0] addr_v [NPORT];
   logic [DATA_W-1:0] din_v  [NPORT];
   logic [DATA_W-1:0] dout_v [NPORT];
   logic              dval_v [NPORT];

   logic [ADDR_W-1:0] eff    [NPORT];
   logic              wr     [NPORT];
   logic              bank_we[NPORT];
   logic [DATA_W-1:0] bank_wd[NPORT];
   logic [DATA_W-1:0] word   [NPORT];
   // rd[b][q]: content of bank b at the address of port q
   logic [DATA_W-1:0] rd     [NPORT][NPORT];

   assign clk_v  = '{clk_l,  clk_r};
   assign csn_v  = '{cs_n_l, cs_n_r};
   assign cs_v   = '{cs_l,   cs_r};
   assign rw_v   = '{rw_l,   rw_r};
   assign ldn_v  = '{ld_n_l, ld_n_r};
   assign oen_v  = '{oe_n_l, oe_n_r};
   assign pipe_v = '{pipe_l, pipe_r};
   assign addr_v = '{addr_l, addr_r};
   assign din_v  = '{din_l,  din_r};

   assign dout_l = dout_v[0];
   assign dval_l = dval_v[0];
   assign dout_r = dout_v[1];
   assign dval_r = dval_v[1];

   for (genvar p = 0; p < NPORT; p++) begin : g_port
      // The stored word is the XOR of both banks; each bank has one writer.
      assign word[p]    = rd[0][p] ^ rd[1][p];
      assign bank_wd[p] = din_v[p] ^ rd[NPORT-1-p][p];

      if (p == LEFT) begin : g_we_left
         assign bank_we[p] = wr[p];
      end else begin : g_we_right
         // same word written by the left port on this edge: left wins
         assign bank_we[p] = wr[p] && !(wr[LEFT] && (eff[LEFT] == eff[p]));
      end

      dpram_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
         .clk      (clk_v[p]),
         .rst_n    (rst_n),
         .cs_n     (csn_v[p]),
         .cs       (cs_v[p]),
         .rw       (rw_v[p]),
         .ld_n     (ldn_v[p]),
         .oe_n     (oen_v[p]),
         .pipe     (pipe_v[p]),
         .addr     (addr_v[p]),
         .rd_word  (word[p]),
         .eff_addr (eff[p]),
         .wr_now   (wr[p]),
         .dout     (dout_v[p]),
         .dval     (dval_v[p])
      );

      dpram_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
         .clk     (clk_v[p]),
         .we      (bank_we[p]),
         .waddr   (eff[p]),
         .wdata   (bank_wd[p]),
         .raddr_a (eff[0]),
         .rdata_a (rd[p][0]),
         .raddr_b (eff[1]),
         .rdata_b (rd[p][1])
      );
   end
endmodule

// File: rtl/dpram_dual_chk.sv
module dpram_dual_chk (
   input logic rst_n,
   input logic clk_l,
   input logic cs_n_l,
   input logic cs_l,
   input logic rw_l,
   input logic oe_n_l,
   input logic pipe_l,
   input logic dval_l,
   input logic clk_r,
   input logic cs_n_r,
   input logic cs_r,
   input logic rw_r,
   input logic oe_n_r,
   input logic pipe_r,
   input logic dval_r
);
   logic sel_l, sel_r;
   assign sel_l = !cs_n_l && cs_l;
   assign sel_r = !cs_n_r && cs_r;

   // R1
   flow_read_valid_chk: assert property (@(posedge clk_l) disable iff (!rst_n)
      (sel_l && rw_l && !pipe_l) |=> (pipe_l || (dval_l == !oe_n_l)));

   // R2
   pipe_read_valid_chk: assert property (@(posedge clk_r) disable iff (!rst_n)
      (sel_r && rw_r && pipe_r) ##1 pipe_r |=> (!pipe_r || (dval_r == !oe_n_r)));

   // R3
   write_no_valid_chk: assert property (@(posedge clk_l) disable iff (!rst_n)
      (sel_l && !rw_l && !pipe_l) |=> (pipe_l || !dval_l));

   // R4
   desel_flow_chk: assert property (@(posedge clk_r) disable iff (!rst_n)
      (!sel_r && !pipe_r) |=> (pipe_r || !dval_r));

   // R5
   desel_pipe_chk: assert property (@(posedge clk_l) disable iff (!rst_n)
      (!sel_l && pipe_l) ##1 (!sel_l && pipe_l) |=> (!pipe_l || !dval_l));

   // R6
   oe_gate_l_chk: assert property (@(posedge clk_l) disable iff (!rst_n)
      oe_n_l |-> !dval_l);

   // R6
   oe_gate_r_chk: assert property (@(posedge clk_r) disable iff (!rst_n)
      oe_n_r |-> !dval_r);

   // R11
   reset_exit_chk: assert property (@(posedge clk_l) disable iff (!rst_n)
      $rose(rst_n) |-> !dval_l);
endmodule

bind dpram_dual dpram_dual_chk u_chk (.*);

// File: tb/tb_dpram_dual.sv
module tb_dpram_dual;
   localparam int AW = 10;
   localparam int DW = 9;
   localparam int DEPTH = 1 << AW;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic          rst_n;
   logic          cs_n_l, cs_l, rw_l, ld_n_l, oe_n_l, pipe_l;
   logic [AW-1:0] addr_l;
   logic [DW-1:0] din_l, dout_l;
   logic          dval_l;
   logic          cs_n_r, cs_r, rw_r, ld_n_r, oe_n_r, pipe_r;
   logic [AW-1:0] addr_r;
   logic [DW-1:0] din_r, dout_r;
   logic          dval_r;

   logic [DW-1:0] ref_mem [DEPTH];
   int n_chk  = 0;
   int n_fail = 0;

   dpram_dual #(.ADDR_W(AW), .DATA_W(DW)) dut (
      .rst_n(rst_n),
      .clk_l(clk), .cs_n_l(cs_n_l), .cs_l(cs_l), .rw_l(rw_l), .ld_n_l(ld_n_l),
      .oe_n_l(oe_n_l), .pipe_l(pipe_l), .addr_l(addr_l), .din_l(din_l),
      .dout_l(dout_l), .dval_l(dval_l),
      .clk_r(clk), .cs_n_r(cs_n_r), .cs_r(cs_r), .rw_r(rw_r), .ld_n_r(ld_n_r),
      .oe_n_r(oe_n_r), .pipe_r(pipe_r), .addr_r(addr_r), .din_r(din_r),
      .dout_r(dout_r), .dval_r(dval_r)
   );

   task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic drv_l(input logic csn, input logic cs, input logic rw, input logic ldn,
                        input logic [AW-1:0] a, input logic [DW-1:0] d);
      cs_n_l = csn; cs_l = cs; rw_l = rw; ld_n_l = ldn; addr_l = a; din_l = d;
   endtask

   task automatic drv_r(input logic csn, input logic cs, input logic rw, input logic ldn,
                        input logic [AW-1:0] a, input logic [DW-1:0] d);
      cs_n_r = csn; cs_r = cs; rw_r = rw; ld_n_r = ldn; addr_r = a; din_r = d;
   endtask

   task automatic idle_both();
      drv_l(1'b1, 1'b0, 1'b1, 1'b0, '0, '0);
      drv_r(1'b1, 1'b0, 1'b1, 1'b0, '0, '0);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      idle_both();
      oe_n_l = 1'b0; oe_n_r = 1'b0; pipe_l = 1'b0; pipe_r = 1'b0;
      repeat (3) tick();
      chk("R11 left valid in reset", {8'h0, dval_l}, 9'h0);
      chk("R11 right valid in reset", {8'h0, dval_r}, 9'h0);
      rst_n = 1'b1;
      tick();
      chk("R11 left valid after reset", {8'h0, dval_l}, 9'h0);
      chk("R11 right valid after reset", {8'h0, dval_r}, 9'h0);
   endtask

   task automatic t_write_read_flow();
      pipe_l = 1'b0;
      for (int i = 0; i < 8; i++) begin
         logic [AW-1:0] a;
         logic [DW-1:0] d;
         a = AW'(i * 3 + 1);
         d = DW'(i * 53 + 17);
         drv_l(1'b0, 1'b1, 1'b0, 1'b0, a, d);
         tick();
         ref_mem[a] = d;
         chk("R3 no valid on write cycle", {8'h0, dval_l}, 9'h0);
      end
      drv_l(1'b0, 1'b1, 1'b0, 1'b0, '0, 9'h155);           tick(); ref_mem[0] = 9'h155;
      drv_l(1'b0, 1'b1, 1'b0, 1'b0, AW'(DEPTH - 1), 9'h0AB); tick(); ref_mem[DEPTH-1] = 9'h0AB;
      for (int i = 7; i >= 0; i--) begin
         logic [AW-1:0] a;
         a = AW'(i * 3 + 1);
         drv_l(1'b0, 1'b1, 1'b1, 1'b0, a, '0);
         tick();
         chk("R1 flow read data", dout_l, ref_mem[a]);
         chk("R1 flow read valid", {8'h0, dval_l}, 9'h1);
      end
      drv_l(1'b0, 1'b1, 1'b1, 1'b0, '0, '0); tick();
      chk("R1 flow read address zero", dout_l, ref_mem[0]);
      drv_l(1'b0, 1'b1, 1'b1, 1'b0, AW'(DEPTH - 1), '0); tick();
      chk("R1 flow read top address", dout_l, ref_mem[DEPTH-1]);
      idle_both();
      tick();
      chk("R5 flow deselect output off", {8'h0, dval_l}, 9'h0);
   endtask

   task automatic t_pipe_right();
      pipe_r = 1'b1;
      for (int i = 0; i < 4; i++) begin
         drv_r(1'b0, 1'b1, 1'b0, 1'b0, AW'(200 + i), DW'(200 + i * 11));
         tick();
         ref_mem[200 + i] = DW'(200 + i * 11);
      end
      idle_both();
      tick();
      drv_r(1'b0, 1'b1, 1'b1, 1'b0, AW'(200), '0);
      tick();
      chk("R2 pipelined nothing after capture edge", {8'h0, dval_r}, 9'h0);
      for (int i = 1; i < 4; i++) begin
         drv_r(1'b0, 1'b1, 1'b1, 1'b0, AW'(200 + i), '0);
         tick();
         chk("R2 pipelined read data", dout_r, ref_mem[200 + i - 1]);
         chk("R2 pipelined read valid", {8'h0, dval_r}, 9'h1);
      end
      idle_both();
      tick();
      chk("R5 pipelined deselect holds last word", dout_r, ref_mem[203]);
      chk("R5 pipelined deselect valid one more cycle", {8'h0, dval_r}, 9'h1);
      tick();
      chk("R5 pipelined deselect output off", {8'h0, dval_r}, 9'h0);
      pipe_r = 1'b0;
   endtask

   task automatic t_cepair();
      logic [1:0] combos [3];
      combos = '{2'b11, 2'b00, 2'b10};
      pipe_l = 1'b0;
      foreach (combos[k]) begin
         drv_l(combos[k][1], combos[k][0], 1'b0, 1'b0, AW'(1), ~ref_mem[1]);
         tick();
         drv_l(combos[k][1], combos[k][0], 1'b1, 1'b0, AW'(1), '0);
         tick();
         chk("R4 no valid while deselected", {8'h0, dval_l}, 9'h0);
         drv_l(1'b0, 1'b1, 1'b1, 1'b0, AW'(1), '0);
         tick();
         chk("R4 deselected write ignored", dout_l, ref_mem[1]);
      end
      idle_both();
   endtask

   task automatic t_oe();
      pipe_l = 1'b0;
      drv_l(1'b0, 1'b1, 1'b1, 1'b0, AW'(4), '0);
      tick();
      idle_both();
      oe_n_l = 1'b1; #1;
      chk("R6 oe high kills valid", {8'h0, dval_l}, 9'h0);
      oe_n_l = 1'b0; #1;
      chk("R6 oe low restores valid", {8'h0, dval_l}, 9'h1);
      chk("R6 data held across oe", dout_l, ref_mem[4]);
      pipe_r = 1'b1;
      drv_r(1'b0, 1'b1, 1'b1, 1'b0, AW'(201), '0);
      tick();
      idle_both();
      tick();
      oe_n_r = 1'b1; #1;
      chk("R6 pipelined oe high kills valid", {8'h0, dval_r}, 9'h0);
      oe_n_r = 1'b0; #1;
      chk("R6 pipelined oe low data", dout_r, ref_mem[201]);
      pipe_r = 1'b0;
      tick();
   endtask

   task automatic t_strobe();
      logic [DW-1:0] d;
      pipe_l = 1'b0;
      drv_l(1'b0, 1'b1, 1'b1, 1'b0, AW'(7), '0);
      tick();
      chk("R7 loaded address read", dout_l, ref_mem[7]);
      drv_l(1'b0, 1'b1, 1'b1, 1'b1, AW'(10), '0);
      tick();
      chk("R7 held address ignores pins", dout_l, ref_mem[7]);
      d = ~ref_mem[7];
      drv_l(1'b0, 1'b1, 1'b0, 1'b1, AW'(10), d);
      tick();
      ref_mem[7] = d;
      drv_l(1'b0, 1'b1, 1'b1, 1'b0, AW'(7), '0);
      tick();
      chk("R7 write went to held address", dout_l, ref_mem[7]);
      drv_l(1'b0, 1'b1, 1'b1, 1'b0, AW'(10), '0);
      tick();
      chk("R7 pin address untouched", dout_l, ref_mem[10]);
      idle_both();
   endtask

   task automatic t_collide();
      pipe_l = 1'b0; pipe_r = 1'b0;
      drv_l(1'b0, 1'b1, 1'b0, 1'b0, AW'(300), 9'h0C3);
      drv_r(1'b0, 1'b1, 1'b0, 1'b0, AW'(300), 9'h13C);
      tick();
      ref_mem[300] = 9'h0C3;
      drv_l(1'b0, 1'b1, 1'b0, 1'b0, AW'(301), 9'h011);
      drv_r(1'b0, 1'b1, 1'b0, 1'b0, AW'(302), 9'h122);
      tick();
      ref_mem[301] = 9'h011; ref_mem[302] = 9'h122;
      drv_l(1'b0, 1'b1, 1'b1, 1'b0, AW'(300), '0);
      drv_r(1'b0, 1'b1, 1'b1, 1'b0, AW'(300), '0);
      tick();
      chk("R8 left wins same-address write (left)", dout_l, ref_mem[300]);
      chk("R8 left wins same-address write (right)", dout_r, ref_mem[300]);
      drv_l(1'b0, 1'b1, 1'b1, 1'b0, AW'(302), '0);
      drv_r(1'b0, 1'b1, 1'b1, 1'b0, AW'(301), '0);
      tick();
      chk("R10 right write to own address stored", dout_l, ref_mem[302]);
      chk("R10 left write to own address stored", dout_r, ref_mem[301]);
      idle_both();
   endtask

   task automatic t_rw_same();
      logic [DW-1:0] old;
      pipe_r = 1'b0;
      old = ref_mem[4];
      drv_l(1'b0, 1'b1, 1'b0, 1'b0, AW'(4), 9'h1AA);
      drv_r(1'b0, 1'b1, 1'b1, 1'b0, AW'(4), '0);
      tick();
      ref_mem[4] = 9'h1AA;
      chk("R9 read during other-port write returns old", dout_r, old);
      drv_l(1'b1, 1'b0, 1'b1, 1'b0, '0, '0);
      tick();
      chk("R9 next read returns new", dout_r, ref_mem[4]);
      idle_both();
   endtask

   task automatic t_mixed();
      pipe_l = 1'b1; pipe_r = 1'b0;
      drv_l(1'b0, 1'b1, 1'b1, 1'b0, AW'(1), '0);
      drv_r(1'b0, 1'b1, 1'b1, 1'b0, AW'(200), '0);
      tick();
      chk("R10 right flow unaffected by left mode", dout_r, ref_mem[200]);
      drv_l(1'b0, 1'b1, 1'b1, 1'b0, AW'(4), '0);
      drv_r(1'b0, 1'b1, 1'b1, 1'b0, AW'(201), '0);
      tick();
      chk("R10 left pipelined first word", dout_l, ref_mem[1]);
      chk("R10 right flow second word", dout_r, ref_mem[201]);
      idle_both();
      tick();
      chk("R10 left pipelined second word", dout_l, ref_mem[4]);
      chk("R10 right off after deselect", {8'h0, dval_r}, 9'h0);
      pipe_l = 1'b0;
      tick();
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(8 * 200000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      t_reset();
      t_write_read_flow();
      t_pipe_right();
      t_cepair();
      t_oe();
      t_strobe();
      t_collide();
      t_rw_same();
      t_mixed();
      finish_run();
   end
endmodule